// File: doc/BRIEF.md
# Branch Target Instruction Cache

This block sits next to the fetch unit and remembers branches that were recently taken. Each stored entry holds the branch's word address, the word address of its target, and the first two instruction words found at that target. When the fetch address matches a stored branch, the block returns both target instructions combinationally, in the same cycle as the branch fetch. It also returns the address from which sequential fetch resumes on the taken path. That address is not stored; it is derived on every hit by adding two words to the stored target.

A hit acts as an implicit taken prediction and a miss as a not-taken prediction. There are no counter bits, so the scheme behaves as a one-bit predictor. The execute stage reports every resolved branch on the update port:
- A taken branch that misses allocates an entry. It uses the lowest-numbered free slot, or a round-robin victim when every slot is valid.
- A taken branch that hits rewrites its own entry in place.
- A not-taken branch that hits clears its entry.
- A not-taken branch that misses changes nothing.

Top module: `tgt_insn_cache`

## Requirements
- R1: After reset no entry is valid, so every lookup misses.
- R2: After a taken update for address A, a lookup of A from the next cycle on hits and returns the two reported instruction words on `insn0_o`/`insn1_o`.
- R3: On a hit, `cont_addr_o` equals the stored target address with bits [1:0] cleared, plus 8.
- R4: A not-taken update for an address with no entry allocates nothing; a later lookup of it misses.
- R5: A not-taken update whose address hits invalidates that entry; a later lookup misses.
- R6: A taken update whose address already hits overwrites that entry's target and words without using a further slot.
- R7: A taken update that misses fills the lowest-numbered invalid slot. When all slots are valid, it replaces the slot at the victim pointer, which starts at 0 and advances by one (wrapping) only on such a replacement.
- R8: An update and a lookup of the same address in the same cycle return the contents held before the update; the change is visible from the next cycle.
- R9: With `fetch_valid_i` low, `hit_o` is low.
- R10: Tags are the address bits [31:2]: a lookup differing only in bits [1:0] hits, and one differing in bit 31 misses.
- R11: On a miss, `insn0_o`, `insn1_o` and `cont_addr_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fetch_valid_i | input | 1 | Fetch address is valid this cycle |
| fetch_addr_i | input | 32 | Current instruction fetch byte address |
| upd_valid_i | input | 1 | A resolved branch is reported this cycle |
| upd_branch_addr_i | input | 32 | Byte address of the resolved branch |
| upd_taken_i | input | 1 | Resolved direction, 1 = taken |
| upd_target_addr_i | input | 32 | Byte address of the branch target |
| upd_insn0_i | input | 32 | Instruction word at the target |
| upd_insn1_i | input | 32 | Instruction word following the target |
| hit_o | output | 1 | Fetch address matches a stored branch (predict taken) |
| insn0_o | output | 32 | First target instruction on hit |
| insn1_o | output | 32 | Second target instruction on hit |
| cont_addr_o | output | 32 | Address at which fetch resumes after the two words |

## Verification
The case that is hardest to reach from the ports is the interaction between free-slot allocation and the round-robin pointer. A slot freed by a not-taken update must be refilled ahead of the pointer, and the pointer must keep its position while that happens. The stimulus first fills every slot and then forces two replacements, which moves the pointer to 2. It then invalidates a middle slot and allocates twice more. Which older branches are still present afterwards shows whether the freed slot was used first and the pointer held its position.

// File: rtl/tic_pkg.sv
package tic_pkg;
  localparam int unsigned WORD_LSB = 2;

  typedef enum logic [1:0] {
    UPD_NONE,
    UPD_REFRESH,
    UPD_ALLOC,
    UPD_DROP
  } upd_op_e;
endpackage

// File: rtl/tic_tag_match.sv
module tic_tag_match #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned TAG_W   = 30,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] vld_i,
  input  logic [TAG_W-1:0]   tags_i [ENTRIES],
  input  logic [TAG_W-1:0]   key_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = vld_i[g] && (tags_i[g] == key_i);
  end

  // tags are kept unique, so at most one bit is set
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |match;
endmodule

// File: rtl/tic_victim.sv
module tic_victim #(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ENTRIES-1:0] vld_i,
  input  logic               alloc_i,
  output logic [IDX_W-1:0]   alloc_idx_o,
  output logic [IDX_W-1:0]   ptr_o
);
  logic             full;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] ptr_q;

  // lowest-numbered invalid slot
  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld_i[i]) free_idx = IDX_W'(i);
    end
  end

  assign full        = &vld_i;
  assign alloc_idx_o = full ? ptr_q : free_idx;
  assign ptr_o       = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (alloc_i && full) begin
      ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + IDX_W'(1);
    end
  end
endmodule

// File: rtl/tgt_insn_cache.sv
module tgt_insn_cache
  import tic_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned TAG_W  = ADDR_W - WORD_LSB,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_valid_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_branch_addr_i,
  input  logic              upd_taken_i,
  input  logic [ADDR_W-1:0] upd_target_addr_i,
  input  logic [DATA_W-1:0] upd_insn0_i,
  input  logic [DATA_W-1:0] upd_insn1_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] insn0_o,
  output logic [DATA_W-1:0] insn1_o,
  output logic [ADDR_W-1:0] cont_addr_o
);
  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [TAG_W-1:0]   tgt_q  [ENTRIES];
  logic [DATA_W-1:0]  w0_q   [ENTRIES];
  logic [DATA_W-1:0]  w1_q   [ENTRIES];

  logic             f_hit, upd_hit;
  logic [IDX_W-1:0] f_idx, upd_idx, alloc_idx, wr_idx, victim_ptr;
  upd_op_e          op;

  tic_tag_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_fetch_match (
    .vld_i (vld_q),
    .tags_i(tag_q),
    .key_i (fetch_addr_i[ADDR_W-1:WORD_LSB]),
    .hit_o (f_hit),
    .idx_o (f_idx)
  );

  tic_tag_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_upd_match (
    .vld_i (vld_q),
    .tags_i(tag_q),
    .key_i (upd_branch_addr_i[ADDR_W-1:WORD_LSB]),
    .hit_o (upd_hit),
    .idx_o (upd_idx)
  );

  tic_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vld_i      (vld_q),
    .alloc_i    (op == UPD_ALLOC),
    .alloc_idx_o(alloc_idx),
    .ptr_o      (victim_ptr)
  );

  always_comb begin
    op = UPD_NONE;
    if (upd_valid_i) begin
      if (upd_taken_i) op = upd_hit ? UPD_REFRESH : UPD_ALLOC;
      else if (upd_hit) op = UPD_DROP;
    end
  end

  assign wr_idx = (op == UPD_REFRESH) ? upd_idx : alloc_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
    end else begin
      case (op)
        UPD_ALLOC: vld_q[alloc_idx] <= 1'b1;
        UPD_DROP:  vld_q[upd_idx]   <= 1'b0;
        default:   ;
      endcase
    end
  end

  // payload needs no reset: guarded by vld_q
  always_ff @(posedge clk_i) begin
    if (op == UPD_REFRESH || op == UPD_ALLOC) begin
      tag_q[wr_idx] <= upd_branch_addr_i[ADDR_W-1:WORD_LSB];
      tgt_q[wr_idx] <= upd_target_addr_i[ADDR_W-1:WORD_LSB];
      w0_q[wr_idx]  <= upd_insn0_i;
      w1_q[wr_idx]  <= upd_insn1_i;
    end
  end

  assign hit_o       = fetch_valid_i && f_hit;
  assign insn0_o     = hit_o ? w0_q[f_idx] : '0;
  assign insn1_o     = hit_o ? w1_q[f_idx] : '0;
  assign cont_addr_o = hit_o ? {tgt_q[f_idx] + TAG_W'(2), {WORD_LSB{1'b0}}} : '0;
endmodule

// File: rtl/tic_checker.sv
module tic_checker #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fetch_valid_i,
  input logic [ADDR_W-1:0] fetch_addr_i,
  input logic              upd_valid_i,
  input logic [ADDR_W-1:0] upd_branch_addr_i,
  input logic              upd_taken_i,
  input logic [ADDR_W-1:0] upd_target_addr_i,
  input logic [DATA_W-1:0] upd_insn0_i,
  input logic [DATA_W-1:0] upd_insn1_i,
  input logic              hit_o,
  input logic [DATA_W-1:0] insn0_o,
  input logic [DATA_W-1:0] insn1_o,
  input logic [ADDR_W-1:0] cont_addr_o,
  input logic [ENTRIES-1:0] vld_q,
  input logic              upd_hit,
  input logic [IDX_W-1:0]  victim_ptr
);
  logic repl;
  assign repl = upd_valid_i && upd_taken_i && !upd_hit && (&vld_q);

  p_idle_no_hit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_valid_i |-> !hit_o);

  p_miss_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (insn0_o == '0 && insn1_o == '0 && cont_addr_o == '0));

  p_learn_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_taken_i) ##1
    (fetch_valid_i && fetch_addr_i[ADDR_W-1:2] == $past(upd_branch_addr_i[ADDR_W-1:2]))
    |-> (hit_o && insn0_o == $past(upd_insn0_i) && insn1_o == $past(upd_insn1_i)));

  p_cont_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_taken_i) ##1
    (fetch_valid_i && fetch_addr_i[ADDR_W-1:2] == $past(upd_branch_addr_i[ADDR_W-1:2]))
    |-> (cont_addr_o == {$past(upd_target_addr_i[ADDR_W-1:2]), 2'b00} + ADDR_W'(8)));

  p_forget_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !upd_taken_i) ##1
    (fetch_valid_i && fetch_addr_i[ADDR_W-1:2] == $past(upd_branch_addr_i[ADDR_W-1:2]))
    |-> !hit_o);

  p_nt_no_alloc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !upd_taken_i) |=> ($countones(vld_q) <= $past($countones(vld_q))));

  p_ptr_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !repl |=> $stable(victim_ptr));

  p_ptr_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    repl |=> (victim_ptr == (($past(victim_ptr) == IDX_W'(ENTRIES - 1)) ? '0 : $past(victim_ptr) + IDX_W'(1))));
endmodule

bind tgt_insn_cache tic_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENTRIES(ENTRIES)
) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .fetch_valid_i    (fetch_valid_i),
  .fetch_addr_i     (fetch_addr_i),
  .upd_valid_i      (upd_valid_i),
  .upd_branch_addr_i(upd_branch_addr_i),
  .upd_taken_i      (upd_taken_i),
  .upd_target_addr_i(upd_target_addr_i),
  .upd_insn0_i      (upd_insn0_i),
  .upd_insn1_i      (upd_insn1_i),
  .hit_o            (hit_o),
  .insn0_o          (insn0_o),
  .insn1_o          (insn1_o),
  .cont_addr_o      (cont_addr_o),
  .vld_q            (vld_q),
  .upd_hit          (upd_hit),
  .victim_ptr       (victim_ptr)
);

// File: tb/tgt_insn_cache_test.sv
`timescale 1ns/1ps
module tgt_insn_cache_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fetch_valid_i = 1'b0;
  logic [31:0] fetch_addr_i = '0;
  logic        upd_valid_i = 1'b0;
  logic [31:0] upd_branch_addr_i = '0;
  logic        upd_taken_i = 1'b0;
  logic [31:0] upd_target_addr_i = '0;
  logic [31:0] upd_insn0_i = '0;
  logic [31:0] upd_insn1_i = '0;
  logic        hit_o;
  logic [31:0] insn0_o, insn1_o, cont_addr_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk_i = ~clk_i;

  tgt_insn_cache uut (.*);

  // upd=1: report branch; upd=0: lookup with expectation
  typedef struct packed {
    logic        upd;
    logic        taken_or_hit;
    logic [31:0] addr;
    logic [31:0] tgt;
    logic [31:0] w0;
    logic [31:0] w1;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 32'h0000_1000, 32'h0,         32'h0,         32'h0,         8'd1},
    '{1'b1, 1'b1, 32'h0000_1000, 32'h0000_2000, 32'h1111_0000, 32'h2222_0000, 8'd2},
    '{1'b0, 1'b1, 32'h0000_1000, 32'h0000_2000, 32'h1111_0000, 32'h2222_0000, 8'd3},
    '{1'b0, 1'b1, 32'h0000_1002, 32'h0000_2000, 32'h1111_0000, 32'h2222_0000, 8'd10},
    '{1'b0, 1'b0, 32'h8000_1000, 32'h0,         32'h0,         32'h0,         8'd10},
    '{1'b1, 1'b0, 32'h0000_3000, 32'h0000_5000, 32'h5,         32'h6,         8'd4},
    '{1'b0, 1'b0, 32'h0000_3000, 32'h0,         32'h0,         32'h0,         8'd4},
    '{1'b1, 1'b1, 32'h0000_1000, 32'h0000_4004, 32'h3333_0000, 32'h4444_0000, 8'd6},
    '{1'b0, 1'b1, 32'h0000_1000, 32'h0000_4004, 32'h3333_0000, 32'h4444_0000, 8'd6},
    '{1'b1, 1'b0, 32'h0000_1000, 32'h0,         32'h0,         32'h0,         8'd5},
    '{1'b0, 1'b0, 32'h0000_1000, 32'h0,         32'h0,         32'h0,         8'd5}
  };

  task automatic check(input int req, input logic eh, input logic [31:0] ew0, ew1, et);
    logic [31:0] ec;
    ec = eh ? ({et[31:2], 2'b00} + 32'd8) : 32'd0;
    if (!eh) begin ew0 = '0; ew1 = '0; end
    n_checks++;
    if (hit_o !== eh || insn0_o !== ew0 || insn1_o !== ew1 || cont_addr_o !== ec) begin
      n_fail++;
      $display("FAIL R%0d: hit=%0b w0=%h w1=%h cont=%h, expected hit=%0b w0=%h w1=%h cont=%h",
               req, hit_o, insn0_o, insn1_o, cont_addr_o, eh, ew0, ew1, ec);
    end
  endtask

  task automatic report(input logic tk, input logic [31:0] a, t, w0, w1);
    @(negedge clk_i);
    upd_valid_i = 1'b1; upd_taken_i = tk; upd_branch_addr_i = a;
    upd_target_addr_i = t; upd_insn0_i = w0; upd_insn1_i = w1;
    @(negedge clk_i);
    upd_valid_i = 1'b0;
  endtask

  task automatic look(input int req, input logic [31:0] a, input logic eh,
                      input logic [31:0] t, w0, w1);
    @(negedge clk_i);
    fetch_valid_i = 1'b1; fetch_addr_i = a;
    #1 check(req, eh, w0, w1, t);
    fetch_valid_i = 1'b0;
  endtask

  function automatic logic [31:0] ea(int k); return 32'h0001_0000 + 32'(k) * 32'h40; endfunction
  function automatic logic [31:0] et(int k); return 32'h0002_0000 + 32'(k) * 32'h100; endfunction
  function automatic logic [31:0] e0(int k); return 32'hA000_0000 + 32'(k); endfunction
  function automatic logic [31:0] e1(int k); return 32'hB000_0000 + 32'(k); endfunction

  task automatic fill(int k);
    report(1'b1, ea(k), et(k), e0(k), e1(k));
  endtask

  task automatic probe(int req, int k, logic eh);
    look(req, ea(k), eh, et(k), e0(k), e1(k));
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); @(negedge clk_i); rst_ni = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: fresh state misses
    look(1, 32'h0000_1000, 1'b0, 0, 0, 0);

    // table walk: R2 R3 R4 R5 R6 R10 R11
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].upd)
        report(VECS[i].taken_or_hit, VECS[i].addr, VECS[i].tgt, VECS[i].w0, VECS[i].w1);
      else
        look(int'(VECS[i].req), VECS[i].addr, VECS[i].taken_or_hit,
             VECS[i].tgt, VECS[i].w0, VECS[i].w1);
    end

    // R9: stored entry, but no fetch strobe
    report(1'b1, 32'h0000_6000, 32'h0000_7000, 32'h77, 32'h88);
    @(negedge clk_i);
    fetch_valid_i = 1'b0; fetch_addr_i = 32'h0000_6000;
    #1 check(9, 1'b0, 0, 0, 0);

    // R8: same-cycle update returns old contents, new ones next cycle
    @(negedge clk_i);
    upd_valid_i = 1'b1; upd_taken_i = 1'b1; upd_branch_addr_i = 32'h0000_6000;
    upd_target_addr_i = 32'h0000_9000; upd_insn0_i = 32'h99; upd_insn1_i = 32'haa;
    fetch_valid_i = 1'b1; fetch_addr_i = 32'h0000_6000;
    #1 check(8, 1'b1, 32'h77, 32'h88, 32'h0000_7000);
    @(negedge clk_i);
    upd_valid_i = 1'b0;
    #1 check(8, 1'b1, 32'h99, 32'haa, 32'h0000_9000);
    fetch_valid_i = 1'b0;
    // R8: new address is not visible in its own update cycle
    @(negedge clk_i);
    upd_valid_i = 1'b1; upd_taken_i = 1'b1; upd_branch_addr_i = 32'h0000_6100;
    upd_target_addr_i = 32'h0000_6200; upd_insn0_i = 32'h1; upd_insn1_i = 32'h2;
    fetch_valid_i = 1'b1; fetch_addr_i = 32'h0000_6100;
    #1 check(8, 1'b0, 0, 0, 0);
    @(negedge clk_i);
    upd_valid_i = 1'b0;
    #1 check(8, 1'b1, 32'h1, 32'h2, 32'h0000_6200);
    fetch_valid_i = 1'b0;

    // R1: mid-run reset clears everything
    do_reset();
    look(1, 32'h0000_6000, 1'b0, 0, 0, 0);

    // R7 / R6: replacement order
    for (int k = 0; k < 8; k++) fill(k);
    fill(0);                 // in-place refresh, no slot used (R6)
    fill(8);                 // full: replaces slot 0 (E0), ptr -> 1
    probe(7, 0, 1'b0);
    probe(7, 1, 1'b1);
    probe(7, 8, 1'b1);
    fill(9);                 // replaces slot 1 (E1), ptr -> 2
    probe(7, 1, 1'b0);
    probe(7, 2, 1'b1);
    report(1'b0, ea(4), 0, 0, 0);  // free slot 4 (R5)
    probe(5, 4, 1'b0);
    fill(10);                // goes to free slot 4, ptr stays 2
    probe(7, 2, 1'b1);
    probe(7, 10, 1'b1);
    fill(11);                // full: replaces slot 2 (E2)
    probe(7, 2, 1'b0);
    probe(7, 3, 1'b1);
    probe(7, 9, 1'b1);
    probe(7, 11, 1'b1);

    repeat (2) @(negedge clk_i);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule